// File: doc/BRIEF.md
# Host Command and Interrupt Register

This block is the host-facing control point of a multi-channel network controller. It takes 32-bit writes from a host register port. Each write can do several things in one cycle: start or halt a transmit or receive channel, acknowledge serviced work, request a software interrupt, enable or disable interrupts, load the transmit interrupt threshold, or reset the adapter's event state. The block owns no data path and does no bus decoding. It sees only the write strobe with its data and a set of one-cycle event strobes from the channel engines.

Channel engines report five kinds of event. Frames finished on transmit or receive are counted per channel in saturating counters. The other kinds are latched as flags: a channel reaching the end of its list, statistics overflow, and adapter check. The block picks one pending event and presents it in a 16-bit read value as a 3-bit type code plus an 8-bit vector holding the channel number. It drives the interrupt line while interrupts are enabled and an event is presented. An acknowledge always acts on the event being presented at the time of the write. For frame events, the acknowledge count is subtracted from that channel's counter.

Top module: `hostint_ctrl`

## Requirements
- R1: After reset, host_int_o is 0, irq_o is 0, interrupts are disabled, every channel run flag is 0 and the transmit threshold is 4.
- R2: A write with bit 31 set starts the channel whose number is in bits 28:21, on the receive side when bit 19 is 1 and on the transmit side when it is 0. Bit 30 stops that channel. Bit 31 wins when both are set. Channel numbers at or above the channel count change nothing.
- R3: An end-of-list strobe on a channel clears that channel's run flag, unless the same cycle starts it, and it latches an end-of-list event for that channel.
- R4: host_int_o carries the presented type in bits 4:2 and the channel vector in bits 12:5, with every other bit 0. Type codes: 0 none, 1 transmit frame, 2 statistics overflow, 3 receive frame, 4 software request, 5 transmit end-of-list, 6 adapter check, 7 receive end-of-list.
- R5: Adapter check (type 6, vector 0) is presented whenever it is pending. Otherwise the pending type with the lowest code is presented, and within a type the lowest channel wins.
- R6: Each frame strobe adds one to its channel's counter. An acknowledge (bit 29) while a frame type is presented subtracts the count in bits 7:0 from that channel's counter, floored at 0.
- R7: A transmit frame counter is presented only when it is at or above the threshold. Bit 13 loads the threshold from bits 7:0, and a loaded 0 acts as 1. Receive frame counters are presented whenever they are nonzero.
- R8: Bit 12 raises a software request event (type 4, vector 0), which one acknowledge with any count clears.
- R9: An acknowledge while an end-of-list or statistics overflow event is presented clears it. An acknowledge changes nothing while adapter check or no event is presented. An event arriving in the same cycle as its acknowledge stays pending.
- R10: Bit 10 enables interrupts and bit 11 disables them, with disable winning. irq_o is high exactly when interrupts are enabled and the presented type is nonzero.
- R11: Bit 15 clears every counter, flag and run flag, including adapter check. It restores the threshold to 4 and disables interrupts. It overrides every other bit and every event strobe in the same cycle.
- R12: Frame counters saturate at their maximum (255 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command write data |
| tx_eof_i | input | NCH | Per-channel transmit frame done strobe |
| rx_eof_i | input | NCH | Per-channel receive frame done strobe |
| tx_eoc_i | input | NCH | Per-channel transmit end-of-list strobe |
| rx_eoc_i | input | NCH | Per-channel receive end-of-list strobe |
| stat_ovf_i | input | 1 | Statistics overflow strobe |
| adapter_chk_i | input | 1 | Adapter check strobe |
| host_int_o | output | 16 | Presented interrupt type and vector |
| irq_o | output | 1 | Interrupt line |
| tx_run_o | output | NCH | Transmit channel run flags |
| rx_run_o | output | NCH | Receive channel run flags |

## Verification
The assertions check the one-cycle relations on every cycle. These are: start and end-of-list effects on the run flags, adapter check taking over and staying through acknowledges, adapter reset clearing all visible state, disable silencing the line, and the vector staying within the channel range. Only the bench scenarios can show behaviour that depends on history. That covers the exact drain order of every mix of pending flag events, counter arithmetic under partial acknowledges, threshold gating and reloading, and saturation after hundreds of frame strobes.

// File: rtl/hic_pkg.sv
package hic_pkg;

  typedef enum logic [2:0] {
    IT_NONE   = 3'd0,
    IT_TX_EOF = 3'd1,
    IT_STAT   = 3'd2,
    IT_RX_EOF = 3'd3,
    IT_DUMMY  = 3'd4,
    IT_TX_EOC = 3'd5,
    IT_ADCHK  = 3'd6,
    IT_RX_EOC = 3'd7
  } irq_type_e;

  localparam int unsigned CB_GO     = 31;
  localparam int unsigned CB_STOP   = 30;
  localparam int unsigned CB_ACK    = 29;
  localparam int unsigned CB_CH_HI  = 28;
  localparam int unsigned CB_CH_LO  = 21;
  localparam int unsigned CB_RX     = 19;
  localparam int unsigned CB_RST    = 15;
  localparam int unsigned CB_LDTHR  = 13;
  localparam int unsigned CB_REQ    = 12;
  localparam int unsigned CB_OFF    = 11;
  localparam int unsigned CB_ON     = 10;
  localparam int unsigned CNT_FLD_W = 8;

  localparam logic [7:0] TX_THR_DEF = 8'd4;

  typedef struct packed {
    logic                 go;
    logic                 stop;
    logic                 ack;
    logic                 rx_sel;
    logic [7:0]           chan;
    logic                 adrst;
    logic                 ld_thr;
    logic                 req_int;
    logic                 ints_off;
    logic                 ints_on;
    logic [CNT_FLD_W-1:0] count;
  } cmd_t;

endpackage

// File: rtl/hic_cmd_decode.sv
module hic_cmd_decode
  import hic_pkg::*;
(
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output cmd_t        cmd_o
);

  logic unused_bits;
  assign unused_bits = ^{wdata_i[20], wdata_i[18:16], wdata_i[14], wdata_i[9:8]};

  always_comb begin
    cmd_o          = '0;
    if (we_i) begin
      cmd_o.go       = wdata_i[CB_GO];
      cmd_o.stop     = wdata_i[CB_STOP];
      cmd_o.ack      = wdata_i[CB_ACK];
      cmd_o.rx_sel   = wdata_i[CB_RX];
      cmd_o.chan     = wdata_i[CB_CH_HI:CB_CH_LO];
      cmd_o.adrst    = wdata_i[CB_RST];
      cmd_o.ld_thr   = wdata_i[CB_LDTHR];
      cmd_o.req_int  = wdata_i[CB_REQ];
      cmd_o.ints_off = wdata_i[CB_OFF];
      cmd_o.ints_on  = wdata_i[CB_ON];
      cmd_o.count    = wdata_i[CNT_FLD_W-1:0];
    end
  end

endmodule

// File: rtl/hic_evt_counter.sv
module hic_evt_counter #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned AMT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [AMT_W-1:0] dec_amt_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int unsigned SW = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 1;
  localparam logic [SW-1:0] MAX_S = SW'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    sum, amt, res;

  always_comb begin
    sum = SW'(cnt_q) + SW'(inc_i);
    if (sum > MAX_S) sum = MAX_S;
    amt = SW'(dec_amt_i);
    res = sum;
    if (dec_i) res = (sum >= amt) ? (sum - amt) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= res[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hic_int_prio.sv
module hic_int_prio
  import hic_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic           adchk_i,
  input  logic           stat_i,
  input  logic           dummy_i,
  input  logic [NCH-1:0] tx_eof_i,
  input  logic [NCH-1:0] rx_eof_i,
  input  logic [NCH-1:0] tx_eoc_i,
  input  logic [NCH-1:0] rx_eoc_i,
  output irq_type_e      type_o,
  output logic [7:0]     vec_o
);

  function automatic logic [7:0] lowest(input logic [NCH-1:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) r = 8'(i);
    end
    return r;
  endfunction

  always_comb begin
    type_o = IT_NONE;
    vec_o  = '0;
    if (adchk_i) begin
      type_o = IT_ADCHK;
    end else if (|tx_eof_i) begin
      type_o = IT_TX_EOF;
      vec_o  = lowest(tx_eof_i);
    end else if (stat_i) begin
      type_o = IT_STAT;
    end else if (|rx_eof_i) begin
      type_o = IT_RX_EOF;
      vec_o  = lowest(rx_eof_i);
    end else if (dummy_i) begin
      type_o = IT_DUMMY;
    end else if (|tx_eoc_i) begin
      type_o = IT_TX_EOC;
      vec_o  = lowest(tx_eoc_i);
    end else if (|rx_eoc_i) begin
      type_o = IT_RX_EOC;
      vec_o  = lowest(rx_eoc_i);
    end
  end

endmodule

// File: rtl/hostint_ctrl.sv
module hostint_ctrl
  import hic_pkg::*;
#(
  parameter int unsigned NCH   = 2,
  parameter int unsigned CNT_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_we_i,
  input  logic [31:0]    cmd_wdata_i,
  input  logic [NCH-1:0] tx_eof_i,
  input  logic [NCH-1:0] rx_eof_i,
  input  logic [NCH-1:0] tx_eoc_i,
  input  logic [NCH-1:0] rx_eoc_i,
  input  logic           stat_ovf_i,
  input  logic           adapter_chk_i,
  output logic [15:0]    host_int_o,
  output logic           irq_o,
  output logic [NCH-1:0] tx_run_o,
  output logic [NCH-1:0] rx_run_o
);

  localparam int unsigned CMPW = (CNT_W > 8) ? CNT_W : 8;

  cmd_t       cmd;
  irq_type_e  cur_type;
  logic [7:0] cur_vec;
  logic       ack_here;

  logic [CNT_W-1:0] tx_cnt [NCH];
  logic [CNT_W-1:0] rx_cnt [NCH];
  logic [NCH-1:0]   tx_ok, rx_nz, tx_dec, rx_dec, ch_hit;
  logic [NCH-1:0]   tx_eoc_q, rx_eoc_q, tx_run_q, rx_run_q;
  logic             adchk_q, stat_q, dummy_q, int_en_q;
  logic [7:0]       thr_q, eff_thr;

  hic_cmd_decode u_dec (
    .we_i    (cmd_we_i),
    .wdata_i (cmd_wdata_i),
    .cmd_o   (cmd)
  );

  assign ack_here = cmd.ack & ~cmd.adrst;
  assign eff_thr  = (thr_q == 8'd0) ? 8'd1 : thr_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_hit[g] = (cmd.chan == 8'(g));
    assign tx_dec[g] = ack_here && (cur_type == IT_TX_EOF) && (cur_vec == 8'(g));
    assign rx_dec[g] = ack_here && (cur_type == IT_RX_EOF) && (cur_vec == 8'(g));
    assign tx_ok[g]  = CMPW'(tx_cnt[g]) >= CMPW'(eff_thr);
    assign rx_nz[g]  = |rx_cnt[g];

    hic_evt_counter #(.CNT_W(CNT_W), .AMT_W(CNT_FLD_W)) u_tx_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (cmd.adrst),
      .inc_i     (tx_eof_i[g]),
      .dec_i     (tx_dec[g]),
      .dec_amt_i (cmd.count),
      .cnt_o     (tx_cnt[g])
    );

    hic_evt_counter #(.CNT_W(CNT_W), .AMT_W(CNT_FLD_W)) u_rx_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (cmd.adrst),
      .inc_i     (rx_eof_i[g]),
      .dec_i     (rx_dec[g]),
      .dec_amt_i (cmd.count),
      .cnt_o     (rx_cnt[g])
    );
  end

  hic_int_prio #(.NCH(NCH)) u_prio (
    .adchk_i  (adchk_q),
    .stat_i   (stat_q),
    .dummy_i  (dummy_q),
    .tx_eof_i (tx_ok),
    .rx_eof_i (rx_nz),
    .tx_eoc_i (tx_eoc_q),
    .rx_eoc_i (rx_eoc_q),
    .type_o   (cur_type),
    .vec_o    (cur_vec)
  );

  // single-bit event flags and global state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adchk_q  <= 1'b0;
      stat_q   <= 1'b0;
      dummy_q  <= 1'b0;
      int_en_q <= 1'b0;
      thr_q    <= TX_THR_DEF;
    end else if (cmd.adrst) begin
      adchk_q  <= 1'b0;
      stat_q   <= 1'b0;
      dummy_q  <= 1'b0;
      int_en_q <= 1'b0;
      thr_q    <= TX_THR_DEF;
    end else begin
      adchk_q <= adchk_q | adapter_chk_i;
      stat_q  <= stat_ovf_i | (stat_q & ~(ack_here && cur_type == IT_STAT));
      dummy_q <= cmd.req_int | (dummy_q & ~(ack_here && cur_type == IT_DUMMY));
      if (cmd.ints_off)     int_en_q <= 1'b0;
      else if (cmd.ints_on) int_en_q <= 1'b1;
      if (cmd.ld_thr) thr_q <= cmd.count;
    end
  end

  // per-channel end-of-list flags and run state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_eoc_q <= '0;
      rx_eoc_q <= '0;
      tx_run_q <= '0;
      rx_run_q <= '0;
    end else if (cmd.adrst) begin
      tx_eoc_q <= '0;
      rx_eoc_q <= '0;
      tx_run_q <= '0;
      rx_run_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        tx_eoc_q[i] <= tx_eoc_i[i] |
                       (tx_eoc_q[i] & ~(ack_here && cur_type == IT_TX_EOC && cur_vec == 8'(i)));
        rx_eoc_q[i] <= rx_eoc_i[i] |
                       (rx_eoc_q[i] & ~(ack_here && cur_type == IT_RX_EOC && cur_vec == 8'(i)));
        if (cmd.go && !cmd.rx_sel && ch_hit[i])                        tx_run_q[i] <= 1'b1;
        else if ((cmd.stop && !cmd.rx_sel && ch_hit[i]) || tx_eoc_i[i]) tx_run_q[i] <= 1'b0;
        if (cmd.go && cmd.rx_sel && ch_hit[i])                         rx_run_q[i] <= 1'b1;
        else if ((cmd.stop && cmd.rx_sel && ch_hit[i]) || rx_eoc_i[i])  rx_run_q[i] <= 1'b0;
      end
    end
  end

  assign host_int_o = {3'b000, cur_vec, cur_type, 2'b00};
  assign irq_o      = int_en_q && (cur_type != IT_NONE);
  assign tx_run_o   = tx_run_q;
  assign rx_run_o   = rx_run_q;

endmodule

// File: rtl/hic_checker.sv
module hic_checker #(
  parameter int unsigned NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_we_i,
  input logic [31:0]    cmd_wdata_i,
  input logic [NCH-1:0] tx_eoc_i,
  input logic           adapter_chk_i,
  input logic [15:0]    host_int_o,
  input logic           irq_o,
  input logic [NCH-1:0] tx_run_o,
  input logic [NCH-1:0] rx_run_o
);

  logic wr_rst, go_tx0;
  assign wr_rst = cmd_we_i && cmd_wdata_i[15];
  assign go_tx0 = cmd_we_i && cmd_wdata_i[31] && !cmd_wdata_i[19] &&
                  (cmd_wdata_i[28:21] == 8'd0);

  // R2
  a_r2_go_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_tx0 && !wr_rst) |=> tx_run_o[0]);

  // R3
  a_r3_eoc_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_eoc_i[0] && !go_tx0) |=> !tx_run_o[0]);

  // R5
  a_r5_adchk_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adapter_chk_i && !wr_rst) |=> (host_int_o[4:2] == 3'd6));

  // R9
  a_r9_adchk_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_int_o[4:2] == 3'd6) && !wr_rst) |=> (host_int_o[4:2] == 3'd6));

  // R11
  a_r11_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rst |=> (host_int_o == 16'h0 && !irq_o && tx_run_o == '0 && rx_run_o == '0));

  // R10
  a_r10_off_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wdata_i[11]) |=> !irq_o);

  a_r10_irq_has_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (host_int_o[4:2] != 3'd0));

  // R4
  a_r4_vec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(host_int_o[12:5]) < NCH);

endmodule

bind hostint_ctrl hic_checker #(.NCH(NCH)) u_hic_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_we_i      (cmd_we_i),
  .cmd_wdata_i   (cmd_wdata_i),
  .tx_eoc_i      (tx_eoc_i),
  .adapter_chk_i (adapter_chk_i),
  .host_int_o    (host_int_o),
  .irq_o         (irq_o),
  .tx_run_o      (tx_run_o),
  .rx_run_o      (rx_run_o)
);

// File: tb/test_hostint_ctrl.sv
`timescale 1ns/1ps
module test_hostint_ctrl;

  localparam int NCH = 2;
  localparam logic [31:0] C_GO   = 32'h8000_0000;
  localparam logic [31:0] C_STOP = 32'h4000_0000;
  localparam logic [31:0] C_ACK  = 32'h2000_0000;
  localparam logic [31:0] C_RX   = 32'h0008_0000;
  localparam logic [31:0] C_RST  = 32'h0000_8000;
  localparam logic [31:0] C_THR  = 32'h0000_2000;
  localparam logic [31:0] C_REQ  = 32'h0000_1000;
  localparam logic [31:0] C_OFF  = 32'h0000_0800;
  localparam logic [31:0] C_ON   = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [31:0] cmd_wd = '0;
  logic [NCH-1:0] tx_eof = '0, rx_eof = '0, tx_eoc = '0, rx_eoc = '0;
  logic stat_ovf = 1'b0, adchk = 1'b0;
  logic [15:0] host_int;
  logic irq;
  logic [NCH-1:0] tx_run, rx_run;

  int n_cmp = 0;
  int n_mis = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hostint_ctrl #(.NCH(NCH), .CNT_W(8)) i_hostint_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .tx_eof_i(tx_eof), .rx_eof_i(rx_eof), .tx_eoc_i(tx_eoc), .rx_eoc_i(rx_eoc),
    .stat_ovf_i(stat_ovf), .adapter_chk_i(adchk),
    .host_int_o(host_int), .irq_o(irq), .tx_run_o(tx_run), .rx_run_o(rx_run)
  );

  function automatic logic [31:0] chsel(input int ch);
    return 32'(ch) << 21;
  endfunction

  function automatic logic [15:0] mk(input int t, input int v);
    return 16'((v << 5) | (t << 2));
  endfunction

  // pending bits: 0 stat, 1 rx frame ch1, 2 sw request, 3 tx eol ch0, 4 adapter check, 5 rx eol ch1
  function automatic logic [15:0] expect_int(input logic [5:0] p);
    if (p[4]) return mk(6, 0);
    if (p[0]) return mk(2, 0);
    if (p[1]) return mk(3, 1);
    if (p[2]) return mk(4, 0);
    if (p[3]) return mk(5, 0);
    if (p[5]) return mk(7, 1);
    return 16'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    cmd_we = 1'b1;
    cmd_wd = d;
    @(negedge clk);
    cmd_we = 1'b0;
    cmd_wd = '0;
  endtask

  task automatic ev(input logic [NCH-1:0] te, input logic [NCH-1:0] re,
                    input logic [NCH-1:0] tc, input logic [NCH-1:0] rc,
                    input logic so, input logic ac);
    tx_eof = te; rx_eof = re; tx_eoc = tc; rx_eoc = rc; stat_ovf = so; adchk = ac;
    @(negedge clk);
    tx_eof = '0; rx_eof = '0; tx_eoc = '0; rx_eoc = '0; stat_ovf = 1'b0; adchk = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_mis++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] etx, erx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 host_int", 32'(host_int), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 runs", 32'({tx_run, rx_run}), 0);

    // R2 start/stop sweep, channels 2..3 out of range
    etx = '0; erx = '0;
    for (int d = 0; d < 2; d++) begin
      for (int ch = 0; ch < 4; ch++) begin
        wr(C_GO | (d != 0 ? C_RX : 32'h0) | chsel(ch));
        if (ch < NCH) begin
          if (d != 0) erx[ch] = 1'b1; else etx[ch] = 1'b1;
        end
        chk("R2 go tx", 32'(tx_run), 32'(etx));
        chk("R2 go rx", 32'(rx_run), 32'(erx));
      end
    end
    for (int d = 0; d < 2; d++) begin
      for (int ch = 0; ch < 4; ch++) begin
        wr(C_STOP | (d != 0 ? C_RX : 32'h0) | chsel(ch));
        if (ch < NCH) begin
          if (d != 0) erx[ch] = 1'b0; else etx[ch] = 1'b0;
        end
        chk("R2 stop tx", 32'(tx_run), 32'(etx));
        chk("R2 stop rx", 32'(rx_run), 32'(erx));
      end
    end
    wr(C_GO | C_STOP | C_RX | chsel(1));
    chk("R2 go beats stop", 32'(rx_run), 32'h2);

    // R3 end-of-list
    wr(C_GO | chsel(1));
    chk("R3 tx1 running", 32'(tx_run), 32'h2);
    ev('0, '0, 2'b10, '0, 1'b0, 1'b0);
    chk("R3 run cleared", 32'(tx_run), 32'h0);
    chk("R3 eol presented", 32'(host_int), 32'(mk(5, 1)));
    ev('0, '0, '0, 2'b10, 1'b0, 1'b0);
    chk("R3 rx run cleared", 32'(rx_run), 32'h0);
    wr(C_ACK);
    chk("R9 tx eol acked", 32'(host_int), 32'(mk(7, 1)));
    wr(C_ACK);
    chk("R9 rx eol acked", 32'(host_int), 0);

    // R5/R8/R9 priority and drain sweep over all mixes
    for (int m = 1; m < 64; m++) begin
      logic [5:0] p;
      p = m[5:0];
      wr(C_RST);
      if (p[2]) wr(C_REQ);
      ev('0, p[1] ? 2'b10 : 2'b00, p[3] ? 2'b01 : 2'b00, p[5] ? 2'b10 : 2'b00, p[0], p[4]);
      for (int k = 0; k < 8; k++) begin
        chk("R5 drain order", 32'(host_int), 32'(expect_int(p)));
        if (p == 6'd0 || p[4]) break;
        wr(C_ACK | 32'd1);
        if (p[0]) p[0] = 1'b0;
        else if (p[1]) p[1] = 1'b0;
        else if (p[2]) p[2] = 1'b0;
        else if (p[3]) p[3] = 1'b0;
        else p[5] = 1'b0;
      end
      if (p[4]) begin
        wr(C_ACK | 32'd1);
        chk("R9 adapter check sticky", 32'(host_int), 32'(mk(6, 0)));
      end
    end

    // R8 request cleared by ack with zero count
    wr(C_RST);
    wr(C_REQ);
    chk("R8 sw request", 32'(host_int), 32'(mk(4, 0)));
    wr(C_ACK);
    chk("R8 sw request cleared", 32'(host_int), 0);

    // R5 channel order within type
    wr(C_RST);
    ev('0, 2'b11, '0, '0, 1'b0, 1'b0);
    chk("R5 low channel first", 32'(host_int), 32'(mk(3, 0)));
    wr(C_ACK | 32'd1);
    chk("R5 next channel", 32'(host_int), 32'(mk(3, 1)));
    wr(C_ACK | 32'd1);
    chk("R5 all drained", 32'(host_int), 0);

    // R7 threshold
    wr(C_RST);
    for (int n = 1; n <= 4; n++) begin
      ev(2'b01, '0, '0, '0, 1'b0, 1'b0);
      chk("R7 default threshold", 32'(host_int), (n < 4) ? 32'h0 : 32'(mk(1, 0)));
    end
    wr(C_ACK | 32'd2);
    chk("R7 below threshold hidden", 32'(host_int), 0);
    wr(C_THR | 32'd0);
    chk("R7 zero acts as one", 32'(host_int), 32'(mk(1, 0)));
    wr(C_ACK | 32'd200);
    chk("R6 floor at zero", 32'(host_int), 0);
    wr(C_THR | 32'd2);
    ev(2'b10, '0, '0, '0, 1'b0, 1'b0);
    chk("R7 thr2 one frame", 32'(host_int), 0);
    ev(2'b10, '0, '0, '0, 1'b0, 1'b0);
    chk("R7 thr2 two frames", 32'(host_int), 32'(mk(1, 1)));

    // R6 exact subtraction
    wr(C_RST);
    repeat (5) ev('0, 2'b01, '0, '0, 1'b0, 1'b0);
    wr(C_ACK | 32'd3);
    chk("R6 5-3", 32'(host_int), 32'(mk(3, 0)));
    wr(C_ACK | 32'd1);
    chk("R6 2-1", 32'(host_int), 32'(mk(3, 0)));
    wr(C_ACK | 32'd1);
    chk("R6 1-1", 32'(host_int), 0);

    // R12 saturation
    wr(C_RST);
    rx_eof = 2'b10;
    repeat (300) @(negedge clk);
    rx_eof = '0;
    wr(C_ACK | 32'd254);
    chk("R12 saturated remainder", 32'(host_int), 32'(mk(3, 1)));
    wr(C_ACK | 32'd1);
    chk("R12 drained", 32'(host_int), 0);

    // R10 interrupt enable
    wr(C_RST);
    wr(C_REQ);
    chk("R10 disabled after reset", 32'(irq), 0);
    wr(C_ON);
    chk("R10 enabled", 32'(irq), 1);
    wr(C_ON | C_OFF);
    chk("R10 off wins", 32'(irq), 0);
    wr(C_ON);
    wr(C_ACK);
    chk("R10 no pending no irq", 32'(irq), 0);

    // R11 adapter reset
    wr(C_THR | 32'd1);
    ev('0, '0, '0, '0, 1'b0, 1'b1);
    chk("R11 adapter check up", 32'(host_int), 32'(mk(6, 0)));
    chk("R11 irq up", 32'(irq), 1);
    wr(C_RST | C_GO | C_ON | C_REQ);
    chk("R11 cleared", 32'(host_int), 0);
    chk("R11 irq off", 32'(irq), 0);
    chk("R11 runs off", 32'({tx_run, rx_run}), 0);
    ev(2'b01, '0, '0, '0, 1'b0, 1'b0);
    chk("R11 threshold restored", 32'(host_int), 0);
    wr(C_ON);
    chk("R11 irq disabled after reset", 32'(irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule